// File: doc/BRIEF.md
# Four-Mode Significand Rounding Stage

This stage sits at the end of a floating-point adder or multiplier. It receives an unrounded significand, its exponent and sign, and the three extra bits kept beyond the significand: guard, round and sticky. A flag tells the stage whether the upstream datapath has already shifted the significand one place left to normalize it. From these inputs the stage picks the bit that sits in the last place, the round bit and the sticky bit. It then decides for the selected rounding mode whether to add one unit in the last place, and applies that increment.

An increment can carry out of the top of the significand. In that case the result is shifted right by one and the exponent is raised by one. The stage also reports whether the result is inexact. The result is registered, so it appears one clock after the operand is presented with its valid strobe. Overflow of the exponent to infinity and subnormal operands are left to other stages.

Top module: `rnd_unit`

## Requirements
- R1: Outputs are registered and appear one clock after the inputs. `outValid` follows `inValid` with one clock of delay. Reset clears `outValid`, `outSig`, `outExp` and `outInexact` to zero.
- R2: With `modeIn` = 2'b00 (nearest, ties to even), one ulp is added exactly when round AND (sticky OR last-place bit) is true.
- R3: With `modeIn` = 2'b01 (toward zero), no ulp is ever added and the extra bits are discarded.
- R4: With `modeIn` = 2'b10 (toward +infinity), one ulp is added only when `signIn` = 0 and round OR sticky is 1.
- R5: With `modeIn` = 2'b11 (toward -infinity), one ulp is added only when `signIn` = 1 and round OR sticky is 1.
- R6: With `postNorm` = 0, the significand is used as given and its bit 0 is the last-place bit. `gBit` acts as the round bit, and `rBit` OR `sBit` forms the sticky bit.
- R7: With `postNorm` = 1, the significand is `{sigIn[SIG_W-2:0], gBit}`, so the guard bit lands in bit 0. `rBit` is the round bit and `sBit` is the sticky bit.
- R8: `outInexact` equals round OR sticky, taken after the selection of R6/R7.
- R9: When the increment carries out of the significand, `outSig` becomes a single 1 in its top bit followed by zeros, and `outExp` = `expIn` + 1. In every other case `outExp` = `expIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| modeIn | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| signIn | input | 1 | Sign of the result (1 = negative) |
| postNorm | input | 1 | 1 when a one-place left normalization shift was applied upstream |
| sigIn | input | SIG_W | Unrounded significand |
| expIn | input | EXP_W | Exponent, already adjusted for normalization |
| gBit | input | 1 | Guard bit |
| rBit | input | 1 | Round bit |
| sBit | input | 1 | Sticky bit |
| outValid | output | 1 | Result valid |
| outSig | output | SIG_W | Rounded significand |
| outExp | output | EXP_W | Exponent after carry renormalization |
| outInexact | output | 1 | Result differs from the exact value |

## Verification
In a single cycle, an ulp increment can ripple through an all-ones significand and force the carry renormalization. The same cycle can also include the left-normalized bit selection that moves the guard bit into the last place. Vectors drive an all-ones significand with the round condition set, both with and without `postNorm`. For each one the bench compares the significand, the exponent bump and the inexact flag together against hand-derived values. The bench also pairs vectors that differ only in `postNorm` or only in sign. This shows that the bit selection and the directed-mode sign test change the decision in the way the requirements predict.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rndMode_e;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic useLeftShift;
    logic addUlp;
    logic inexact;
  } rndStrobe_t;
endpackage

// File: rtl/rnd_ctrl.sv
module rnd_ctrl
  import rnd_pkg::*;
(
  input  logic [1:0] modeIn,
  input  logic       signIn,
  input  logic       postNorm,
  input  logic       sigLsb,
  input  logic       gBit,
  input  logic       rBit,
  input  logic       sBit,
  output rndStrobe_t strobe
);
  logic lastBit, roundBit, stickyBit, anyExtra;
  rndMode_e mode;

  assign mode = rndMode_e'(modeIn);

  // bit selection depends on whether a left normalization shift happened (R6, R7)
  always_comb begin
    if (postNorm) begin
      lastBit   = gBit;
      roundBit  = rBit;
      stickyBit = sBit;
    end else begin
      lastBit   = sigLsb;
      roundBit  = gBit;
      stickyBit = rBit | sBit;
    end
  end

  assign anyExtra = roundBit | stickyBit;

  always_comb begin
    strobe.useLeftShift = postNorm;
    strobe.inexact      = anyExtra;
    unique case (mode)
      RM_NEAR_EVEN: strobe.addUlp = roundBit & (stickyBit | lastBit);
      RM_TO_ZERO:   strobe.addUlp = 1'b0;
      RM_UP:        strobe.addUlp = ~signIn & anyExtra;
      RM_DOWN:      strobe.addUlp = signIn & anyExtra;
      default:      strobe.addUlp = 1'b0;
    endcase
  end
endmodule

// File: rtl/rnd_datapath.sv
module rnd_datapath
  import rnd_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SIG_W-1:0] sigIn,
  input  logic [EXP_W-1:0] expIn,
  input  logic             gBit,
  input  rndStrobe_t       strobe,
  output logic             outValid,
  output logic [SIG_W-1:0] outSig,
  output logic [EXP_W-1:0] outExp,
  output logic             outInexact
);
  localparam int SUM_W = SIG_W + 1;

  logic [SIG_W-1:0] alignedSig;
  logic [SUM_W-1:0] sumSig;
  logic             carryOut;
  logic [SIG_W-1:0] nextSig;
  logic [EXP_W-1:0] nextExp;

  assign alignedSig = strobe.useLeftShift ? {sigIn[SIG_W-2:0], gBit} : sigIn;
  assign sumSig     = {1'b0, alignedSig} + {{SIG_W{1'b0}}, strobe.addUlp};
  assign carryOut   = sumSig[SUM_W-1];
  assign nextSig    = carryOut ? sumSig[SUM_W-1:1] : sumSig[SIG_W-1:0];
  assign nextExp    = expIn + {{(EXP_W-1){1'b0}}, carryOut};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outSig     <= '0;
      outExp     <= '0;
      outInexact <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outSig     <= nextSig;
        outExp     <= nextExp;
        outInexact <= strobe.inexact;
      end
    end
  end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       modeIn,
  input  logic             signIn,
  input  logic             postNorm,
  input  logic [SIG_W-1:0] sigIn,
  input  logic [EXP_W-1:0] expIn,
  input  logic             gBit,
  input  logic             rBit,
  input  logic             sBit,
  output logic             outValid,
  output logic [SIG_W-1:0] outSig,
  output logic [EXP_W-1:0] outExp,
  output logic             outInexact
);
  rndStrobe_t strobe;

  rnd_ctrl u_ctrl (
    .modeIn  (modeIn),
    .signIn  (signIn),
    .postNorm(postNorm),
    .sigLsb  (sigIn[0]),
    .gBit    (gBit),
    .rBit    (rBit),
    .sBit    (sBit),
    .strobe  (strobe)
  );

  rnd_datapath #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .sigIn     (sigIn),
    .expIn     (expIn),
    .gBit      (gBit),
    .strobe    (strobe),
    .outValid  (outValid),
    .outSig    (outSig),
    .outExp    (outExp),
    .outInexact(outInexact)
  );
endmodule

// File: rtl/rnd_unit_checker.sv
module rnd_unit_checker #(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       modeIn,
  input logic             signIn,
  input logic             postNorm,
  input logic [SIG_W-1:0] sigIn,
  input logic [EXP_W-1:0] expIn,
  input logic             gBit,
  input logic             rBit,
  input logic             sBit,
  input logic             outValid,
  input logic [SIG_W-1:0] outSig,
  input logic [EXP_W-1:0] outExp,
  input logic             outInexact
);
  localparam logic [SIG_W-1:0] TOP_ONE = {1'b1, {(SIG_W-1){1'b0}}};

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r3_zero_keeps_sig: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeIn == 2'b01 && !postNorm) |=> (outSig == $past(sigIn) && outExp == $past(expIn)));

  a_r4_up_negative_truncates: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeIn == 2'b10 && signIn && postNorm)
      |=> (outSig == {$past(sigIn[SIG_W-2:0]), $past(gBit)}));

  a_r5_down_positive_truncates: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeIn == 2'b11 && !signIn && !postNorm) |=> (outSig == $past(sigIn)));

  a_r8_exact_input: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !gBit && !rBit && !sBit) |=> !outInexact);
  a_r8_guard_inexact: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !postNorm && (gBit || rBit || sBit)) |=> outInexact);

  a_r9_carry_renorm: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !postNorm && modeIn == 2'b00 && (&sigIn) && gBit && rBit)
      |=> (outSig == TOP_ONE && outExp == $past(expIn) + 1'b1));
endmodule

bind rnd_unit rnd_unit_checker #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
  localparam int SIG_W = 24;
  localparam int EXP_W = 8;
  localparam int NV    = 15;

  typedef struct packed {
    logic [1:0]       mode;
    logic             sign;
    logic             pn;
    logic [SIG_W-1:0] sig;
    logic             g;
    logic             r;
    logic             s;
    logic [SIG_W-1:0] expSig;
    logic [EXP_W-1:0] expExp;
    logic             expInx;
    logic [3:0]       req;
  } vec_t;

  // expected results derived by hand from the requirements; exponent in = 8'h80
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 24'h000010, 1'b1, 1'b0, 1'b0, 24'h000010, 8'h80, 1'b1, 4'd2}, // R2 tie, even stays
    '{2'b00, 1'b0, 1'b0, 24'h000011, 1'b1, 1'b0, 1'b0, 24'h000012, 8'h80, 1'b1, 4'd2}, // R2 tie, odd rounds up
    '{2'b00, 1'b0, 1'b0, 24'h000010, 1'b1, 1'b1, 1'b0, 24'h000011, 8'h80, 1'b1, 4'd6}, // R6 r feeds sticky
    '{2'b00, 1'b0, 1'b0, 24'h000010, 1'b0, 1'b1, 1'b1, 24'h000010, 8'h80, 1'b1, 4'd6}, // R6 guard is round bit
    '{2'b00, 1'b0, 1'b0, 24'h123457, 1'b0, 1'b0, 1'b0, 24'h123457, 8'h80, 1'b0, 4'd8}, // R8 exact
    '{2'b01, 1'b0, 1'b0, 24'h7FFFFF, 1'b1, 1'b1, 1'b1, 24'h7FFFFF, 8'h80, 1'b1, 4'd3}, // R3 chop
    '{2'b10, 1'b0, 1'b0, 24'h000100, 1'b0, 1'b0, 1'b1, 24'h000101, 8'h80, 1'b1, 4'd4}, // R4 positive up
    '{2'b10, 1'b1, 1'b0, 24'h000100, 1'b0, 1'b0, 1'b1, 24'h000100, 8'h80, 1'b1, 4'd4}, // R4 negative stays
    '{2'b11, 1'b1, 1'b0, 24'h000100, 1'b0, 1'b1, 1'b0, 24'h000101, 8'h80, 1'b1, 4'd5}, // R5 negative up
    '{2'b11, 1'b0, 1'b0, 24'h000100, 1'b0, 1'b1, 1'b0, 24'h000100, 8'h80, 1'b1, 4'd5}, // R5 positive stays
    '{2'b00, 1'b0, 1'b1, 24'h400000, 1'b1, 1'b1, 1'b0, 24'h800002, 8'h80, 1'b1, 4'd7}, // R7 g in lsb, odd tie
    '{2'b00, 1'b0, 1'b1, 24'h400000, 1'b0, 1'b1, 1'b0, 24'h800000, 8'h80, 1'b1, 4'd7}, // R7 even tie
    '{2'b10, 1'b0, 1'b1, 24'h400000, 1'b1, 1'b0, 1'b0, 24'h800001, 8'h80, 1'b0, 4'd8}, // R8 exact after shift
    '{2'b00, 1'b0, 1'b0, 24'hFFFFFF, 1'b1, 1'b1, 1'b0, 24'h800000, 8'h81, 1'b1, 4'd9}, // R9 carry
    '{2'b10, 1'b0, 1'b1, 24'hFFFFFF, 1'b1, 1'b0, 1'b1, 24'h800000, 8'h81, 1'b1, 4'd9}  // R9 carry with shift
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic [1:0]       modeIn;
  logic             signIn, postNorm;
  logic [SIG_W-1:0] sigIn;
  logic [EXP_W-1:0] expIn;
  logic             gBit, rBit, sBit;
  logic             outValid;
  logic [SIG_W-1:0] outSig;
  logic [EXP_W-1:0] outExp;
  logic             outInexact;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rnd_unit #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    modeIn   = v.mode;
    signIn   = v.sign;
    postNorm = v.pn;
    sigIn    = v.sig;
    expIn    = 8'h80;
    gBit     = v.g;
    rBit     = v.r;
    sBit     = v.s;
    inValid  = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; modeIn = 2'b00; signIn = 1'b0; postNorm = 1'b0;
    sigIn = '0; expIn = '0; gBit = 1'b0; rBit = 1'b0; sBit = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid",   64'(outValid),   64'd0);
    check("R1 reset sig",     64'(outSig),     64'd0);
    check("R1 reset exp",     64'(outExp),     64'd0);
    check("R1 reset inexact", 64'(outInexact), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R%0d vec%0d valid", VECS[i].req, i), 64'(outValid), 64'd1);
      check($sformatf("R%0d vec%0d sig", VECS[i].req, i), 64'(outSig), 64'(VECS[i].expSig));
      check($sformatf("R%0d vec%0d exp", VECS[i].req, i), 64'(outExp), 64'(VECS[i].expExp));
      check($sformatf("R%0d vec%0d inexact", VECS[i].req, i), 64'(outInexact), 64'(VECS[i].expInx));
    end

    // R1 valid drops one cycle after idle input
    @(negedge clk);
    check("R1 idle valid", 64'(outValid), 64'd0);

    // R1 back-to-back: each result appears exactly one clock after its operand
    drive(VECS[1]);
    @(negedge clk);
    check("R1 b2b first sig", 64'(outSig), 64'h000012);
    drive(VECS[13]);
    @(negedge clk);
    inValid = 1'b0;
    check("R1 b2b second sig", 64'(outSig), 64'h800000);
    check("R9 b2b second exp", 64'(outExp), 64'h81);

    // R3 toward zero with all-ones significand: no carry, exponent unchanged
    drive('{2'b01, 1'b1, 1'b0, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 24'h0, 8'h0, 1'b0, 4'd3});
    @(negedge clk);
    inValid = 1'b0;
    check("R3 all-ones sig", 64'(outSig), 64'hFFFFFF);
    check("R3 all-ones exp", 64'(outExp), 64'h80);

    // R1 reset mid-stream clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset sig", 64'(outSig), 64'd0);
    rstN = 1'b1;

    finished = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule